// File: doc/BRIEF.md
# Time-Multiplexed Second-Order IIR Section

This block computes one second-order recursive filter section with a single multiplier, a single adder and four working registers, R1 to R4. A new input sample is accepted once every five clock cycles. A three-bit phase counter steps through a fixed overlapped schedule. In each phase it selects a built-in coefficient, the multiplier operand, the adder operands and the register that is written.

The input sample must be held for a full five-cycle iteration. The filtered output sits in a register that changes once per iteration. A one-cycle strobe marks the cycle after that update. The five coefficients are parameters. Feedback signs live inside the feedback coefficients, so every combining step is an addition:

- y = q(b0·x) + s2
- s2' = q(fa·y) + q(b1·x) + s1
- s1' = q(b2·x) + q(fb·y)

Here q() is the product quantiser and every addition saturates.

Top module: `biquad_tdm`

## Requirements
- R1: While rst_ni is low, y_o and valid_o read 0 and both state terms are cleared. The first iteration after release therefore starts from zero state.
- R2: After reset the phase counter runs 0,1,2,3,4,0,… and starts at 0 on the first rising edge. valid_o is high only in the cycle with phase 2, which is exactly one cycle in five.
- R3: y_o changes only at the rising edge that ends phase 1. It holds its value on every other edge.
- R4: Each iteration's output follows the recursion given above. The multiplier uses coefficients in the order b0, b1, fa, b2, fb during phases 0 to 4.
- R5: Each product is formed at full width. It is then shifted right arithmetically by FW bits (rounding toward minus infinity) and saturated to the signed DW-bit range.
- R6: Every addition saturates to [-2^(DW-1), 2^(DW-1)-1] and never wraps.
- R7: x_i is sampled only in phases 0, 1 and 3. A change of x_i during phases 2 and 4 has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | DW | Signed input sample, held for one iteration |
| y_o | output | DW | Signed filtered sample |
| valid_o | output | 1 | One-cycle strobe in the cycle after y_o updates |

## Verification
In phase 0 the adder closes the previous iteration's s1 sum while the multiplier starts the new iteration from the fresh x_i. The bench provokes this overlap by changing x_i at every iteration boundary with impulses, full-scale square waves and pseudo-random data. It judges the result by comparing y_o on every clock with a behavioural integer model, so a stale or premature operand in that shared cycle shows up as a mismatch. The full-scale square wave sits near the pole frequency, which drives the output update and the feedback-product saturation into the same iterations. Garbage on x_i in phases 2 and 4 tests that only the scheduled sampling cycles matter.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int unsigned PERIOD = 5;
  localparam int unsigned PH_W   = $clog2(PERIOD);

  typedef enum logic [PH_W-1:0] {
    PH_0 = 3'd0,
    PH_1 = 3'd1,
    PH_2 = 3'd2,
    PH_3 = 3'd3,
    PH_4 = 3'd4
  } phase_e;
endpackage

// File: rtl/biquad_sched.sv
module biquad_sched
  import biquad_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_o <= PH_0;
    else if (phase_o == PH_4)   phase_o <= PH_0;
    else                        phase_o <= phase_e'(phase_o + 3'd1);
  end
endmodule

// File: rtl/biquad_coef.sv
module biquad_coef
  import biquad_pkg::*;
#(
  parameter int                     DW = 16,
  parameter logic signed [DW-1:0]   B0 = 16'sd7000,
  parameter logic signed [DW-1:0]   B1 = -16'sd14000,
  parameter logic signed [DW-1:0]   B2 = 16'sd7000,
  parameter logic signed [DW-1:0]   FA = 16'sd26214,
  parameter logic signed [DW-1:0]   FB = -16'sd13107
) (
  input  phase_e                  phase_i,
  output logic signed [DW-1:0]    coef_o
);
  always_comb begin
    unique case (phase_i)
      PH_0:    coef_o = B0;
      PH_1:    coef_o = B1;
      PH_2:    coef_o = FA;
      PH_3:    coef_o = B2;
      default: coef_o = FB;
    endcase
  end
endmodule

// File: rtl/biquad_mul_q.sv
module biquad_mul_q #(
  parameter int DW = 16,
  parameter int FW = 14
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] p_o
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  logic signed [PW-1:0] full, shr;

  always_comb begin
    full = PW'(a_i) * PW'(b_i);
    shr  = full >>> FW;
    if (shr > MAXV)      p_o = MAXV[DW-1:0];
    else if (shr < MINV) p_o = MINV[DW-1:0];
    else                 p_o = shr[DW-1:0];
  end
endmodule

// File: rtl/biquad_add_sat.sv
module biquad_add_sat #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] s_o
);
  logic signed [DW:0] sum;

  always_comb begin
    sum = {a_i[DW-1], a_i} + {b_i[DW-1], b_i};
    if (sum[DW] != sum[DW-1])
      s_o = sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      s_o = sum[DW-1:0];
  end
endmodule

// File: rtl/biquad_tdm.sv
module biquad_tdm
  import biquad_pkg::*;
#(
  parameter int                     DW = 16,
  parameter int                     FW = 14,
  parameter logic signed [DW-1:0]   B0 = 16'sd7000,
  parameter logic signed [DW-1:0]   B1 = -16'sd14000,
  parameter logic signed [DW-1:0]   B2 = 16'sd7000,
  parameter logic signed [DW-1:0]   FA = 16'sd26214,
  parameter logic signed [DW-1:0]   FB = -16'sd13107
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o,
  output logic                 valid_o
);
  phase_e               phase_q;
  logic signed [DW-1:0] coef, mul_op, prod, add_op, sum;
  logic signed [DW-1:0] r1_q, r2_q, r3_q, r4_q;
  logic                 valid_q;

  biquad_sched u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_q)
  );

  biquad_coef #(
    .DW(DW), .B0(B0), .B1(B1), .B2(B2), .FA(FA), .FB(FB)
  ) u_coef (
    .phase_i (phase_q),
    .coef_o  (coef)
  );

  // feedback products take the stored output, the rest take the input
  assign mul_op = (phase_q == PH_2 || phase_q == PH_4) ? r2_q : x_i;

  biquad_mul_q #(.DW(DW), .FW(FW)) u_mul (
    .a_i (coef),
    .b_i (mul_op),
    .p_o (prod)
  );

  assign add_op = (phase_q == PH_0 || phase_q == PH_2) ? r4_q : r3_q;

  biquad_add_sat #(.DW(DW)) u_add (
    .a_i (r1_q),
    .b_i (add_op),
    .s_o (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q    <= '0;
      r2_q    <= '0;
      r3_q    <= '0;
      r4_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (phase_q == PH_1);
      unique case (phase_q)
        PH_0: begin r1_q <= prod; r4_q <= sum; end  // previous s1 closes here
        PH_1: begin r1_q <= prod; r2_q <= sum; end  // output
        PH_2: begin r1_q <= prod; r3_q <= sum; end  // partial s2
        PH_3: begin r1_q <= prod; r3_q <= sum; end  // next s2
        default: r4_q <= prod;                      // adder idle
      endcase
    end
  end

  assign y_o     = r2_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/biquad_tdm_chk.sv
module biquad_tdm_chk #(
  parameter int DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           phase_i,
  input logic signed [DW-1:0] y_i,
  input logic                 valid_i
);
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i <= 3'd4);                                                   // R2
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 3'd4 |=> phase_i == 3'd0);                               // R2
  AST_STROBE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == 3'd1 |=> valid_i);                                       // R2
  AST_STROBE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> phase_i == 3'd2);                                       // R2
  AST_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != 3'd2 |-> $stable(y_i));                                  // R3
  AST_RESET_OUT: assert property (@(posedge clk_i)
    !rst_ni |-> (y_i == '0 && !valid_i));                               // R1
endmodule

bind biquad_tdm biquad_tdm_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .phase_i (phase_q),
  .y_i     (y_o),
  .valid_i (valid_o)
);

// File: tb/tb_biquad_tdm.sv
module tb_biquad_tdm;
  localparam int DW = 16;
  localparam int FW = 14;
  localparam int B0 = 7000, B1 = -14000, B2 = 7000, FA = 26214, FB = -13107;
  localparam int MAXV = 32767, MINV = -32768;

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic signed [DW-1:0] x_i;
  logic signed [DW-1:0] y_o;
  logic                 valid_o;

  int n_chk = 0, n_fail = 0;
  int s1 = 0, s2 = 0, y_ref = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk_i = ~clk_i;

  biquad_tdm dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .x_i (x_i), .y_o (y_o), .valid_o (valid_o)
  );

  function automatic int clamp(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  // R5: full product, arithmetic shift, saturate
  function automatic int qmul(int c, int d);
    return clamp((c * d) >>> FW);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one iteration; entered at the negedge before phase 0
  task automatic run_sample(int x, bit glitch);
    int y_old, p2;
    y_old = y_ref;
    y_ref = clamp(qmul(B0, x) + s2);                     // R4 R6
    p2    = clamp(qmul(B1, x) + s1);
    s2    = clamp(qmul(FA, y_ref) + p2);
    s1    = clamp(qmul(B2, x) + qmul(FB, y_ref));
    x_i   = DW'(x);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check(glitch ? "R7 R4" : "R4 R5 R6 R3", int'(y_o), (k >= 1) ? y_ref : y_old);
      check("R2 strobe", int'(valid_o), (k == 1) ? 1 : 0);
      if (glitch) x_i = (k == 1 || k == 3) ? ~DW'(x) : DW'(x);
    end
  endtask

  task automatic model_reset();
    s1 = 0; s2 = 0; y_ref = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    x_i    = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset y", int'(y_o), 0);
    check("R1 reset strobe", int'(valid_o), 0);
    rst_ni = 1'b1;

    // impulse response
    run_sample(8192, 1'b0);
    for (int i = 0; i < 20; i++) run_sample(0, 1'b0);
    // positive step
    for (int i = 0; i < 30; i++) run_sample(10000, 1'b0);
    // full-scale square wave near pole frequency: saturation (R5 R6)
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < 7; i++) run_sample(MAXV, 1'b0);
      for (int i = 0; i < 7; i++) run_sample(MINV, 1'b0);
    end
    // pseudo-random data, half with garbage in unsampled phases (R7)
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_sample(int'($signed(lfsr)), i[0]);
    end

    // reset in the middle of an iteration
    x_i = 16'sd20000;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async reset y", int'(y_o), 0);
    check("R1 async reset strobe", int'(valid_o), 0);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    // restart from zero state and phase 0
    run_sample(-8192, 1'b0);
    for (int i = 0; i < 15; i++) run_sample(0, 1'b1);
    for (int i = 0; i < 10; i++) run_sample(MINV, 1'b0);

    finish_run();
  end
endmodule